// File: doc/BRIEF.md
# Packet-Atomic Merging Cell Scheduler

This block is the output-side scheduler of a shared-buffer cell switch in which every incoming virtual circuit owns its own queue. The queue holds no cell data, only the buffer addresses (tokens) of its cells, chained into a linked list with a head and a tail pointer. Several incoming circuits may be merged onto one outgoing circuit downstream. The receiver can then only rebuild packets if the cells of different packets never mix on the output. For that reason the scheduler never serves a circuit cell by cell as cells arrive.

A circuit becomes eligible only after the cell that closes one of its packets has been queued. A per-circuit counter of complete, unsent packets serves as the packet-ready flag, so one queue can hold several finished packets behind a partial one. When the output is free, a round-robin choice among eligible circuits picks one packet. Its cells then leave one per slot, back to back, and the choice is not revisited until the closing cell has gone. A mode input turns every written cell into a one-cell packet, which gives ordinary cell switching.

The writer supplies a free buffer address with each cell and takes the address back once it shows up on the read side. Cell storage and label rewriting sit outside this block.

Top module: `vcm_merge_sched`

## Requirements
- R1: After a synchronous active-high reset, every queue is empty, no packet is pending and `rd_valid` is low.
- R2: The cells of one circuit leave in the order they were written, and each cell leaves with the address it was written with on `rd_addr`.
- R3: A circuit is not served before the closing cell of a packet is written. A closing cell written at one clock edge can be sent in the slot that follows that edge.
- R4: Once the first cell of a packet is sent, the remaining cells follow in consecutive slots from the same circuit. No other circuit is served until the closing cell has left.
- R5: `rd_last` is high exactly on the cell that was written as the end of its packet.
- R6: A new packet is taken from the first circuit with a complete packet, searching upward with wraparound from the circuit whose packet was started last. After reset the search begins at circuit 0.
- R7: Any number of complete packets may wait in one queue. Each selection sends only one of them, after which the round-robin search moves on.
- R8: In a slot where no packet is in progress and no circuit holds a complete packet, `rd_valid` is low, even if partial packets are buffered.
- R9: A cell written while `cell_mode` is high is a complete one-cell packet (`rd_last` high when it leaves) whatever `wr_eop` is. The mode is sampled at write time.
- R10: A write and a read on the same circuit in the same slot, including on a queue holding a single cell, keep the list intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cell_mode | input | 1 | 1: every written cell closes its packet |
| wr_valid | input | 1 | A cell token is written this slot |
| wr_vc | input | VC_W (2) | Incoming circuit of the written cell |
| wr_eop | input | 1 | Written cell closes its packet |
| wr_addr | input | ADDR_W (4) | Buffer address of the written cell |
| rd_valid | output | 1 | A cell is sent this slot |
| rd_vc | output | VC_W (2) | Circuit the sent cell is taken from |
| rd_addr | output | ADDR_W (4) | Buffer address of the sent cell |
| rd_last | output | 1 | Sent cell closes its packet |

## Verification
A bench model of per-circuit packet queues predicts every slot's output for a sweep of write densities and packet-closing probabilities over four circuits and sixteen addresses. Sparse writes with rare closings separate "wait for the whole packet" from cell-by-cell service. Dense writes with frequent closings stack several packets per queue, which tests round-robin fairness, back-to-back draining and same-slot push and pop on short queues. A directed partial-packet sequence shows that the output idles while data is buffered. Phases that toggle the cell mode per write tell write-time sampling apart from read-time sampling.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    localparam int unsigned DEF_NUM_VC = 4;
    localparam int unsigned DEF_ADDR_W = 4;

    // Width of an index into n items (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Output phase of the current slot.
    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_FIRST  = 2'd1,
        OUT_MIDDLE = 2'd2
    } out_phase_e;

endpackage

// File: rtl/vcm_link_mem.sv
module vcm_link_mem #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              cell_we,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic              cell_end,
    input  logic              link_we,
    input  logic [ADDR_W-1:0] link_from,
    input  logic [ADDR_W-1:0] link_to,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] rd_next,
    output logic              rd_end
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] next_q [DEPTH];
    logic              end_q  [DEPTH];

    always_ff @(posedge clk) begin
        if (cell_we) end_q[cell_addr] <= cell_end;
        if (link_we) next_q[link_from] <= link_to;
    end

    assign rd_next = next_q[rd_addr];
    assign rd_end  = end_q[rd_addr];
endmodule

// File: rtl/vcm_vc_queue.sv
module vcm_vc_queue #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              push_end,
    input  logic              pop,
    input  logic              pop_end,
    input  logic [ADDR_W-1:0] pop_next,
    output logic [ADDR_W-1:0] head,
    output logic [ADDR_W-1:0] tail,
    output logic              link_we,
    output logic              pkt_ready
);
    logic [CNT_W-1:0] cell_cnt;
    logic [CNT_W-1:0] pkt_cnt;
    logic             single;

    assign single    = (cell_cnt == CNT_W'(1));
    assign pkt_ready = (pkt_cnt != '0);
    // The old tail needs a forward link unless it is leaving this slot.
    assign link_we   = push && (cell_cnt != '0) && !(pop && single);

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            tail     <= '0;
            cell_cnt <= '0;
            pkt_cnt  <= '0;
        end else begin
            if (pop) begin
                if (single) head <= push ? push_addr : head;
                else        head <= pop_next;
            end else if (push && (cell_cnt == '0)) begin
                head <= push_addr;
            end
            if (push) tail <= push_addr;
            cell_cnt <= cell_cnt + CNT_W'(push) - CNT_W'(pop);
            pkt_cnt  <= pkt_cnt + CNT_W'(push && push_end) - CNT_W'(pop && pop_end);
        end
    end
endmodule

// File: rtl/vcm_rr_pick.sv
module vcm_rr_pick #(
    parameter int unsigned NUM_VC = 4,
    parameter int unsigned VC_W   = 2
) (
    input  logic [NUM_VC-1:0] req,
    input  logic [VC_W-1:0]   last,
    output logic [VC_W-1:0]   grant,
    output logic              any
);
    always_comb begin
        grant = last;
        any   = 1'b0;
        for (int unsigned i = 1; i <= NUM_VC; i++) begin
            int unsigned idx;
            idx = (int'(last) + i) % NUM_VC;
            if (!any && req[idx]) begin
                any   = 1'b1;
                grant = VC_W'(idx);
            end
        end
    end
endmodule

// File: rtl/vcm_merge_sched.sv
module vcm_merge_sched
    import vcm_pkg::*;
#(
    parameter int unsigned NUM_VC = DEF_NUM_VC,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    localparam int unsigned VC_W  = idx_width(NUM_VC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_mode,
    input  logic              wr_valid,
    input  logic [VC_W-1:0]   wr_vc,
    input  logic              wr_eop,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              rd_valid,
    output logic [VC_W-1:0]   rd_vc,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_last
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] head_a [NUM_VC];
    logic [ADDR_W-1:0] tail_a [NUM_VC];
    logic [NUM_VC-1:0] ready_v;
    logic [NUM_VC-1:0] link_we_v;

    logic              busy;
    logic [VC_W-1:0]   cur_vc;
    logic [VC_W-1:0]   last_vc;
    logic [VC_W-1:0]   pick_vc;
    logic              any_ready;
    out_phase_e        phase;
    logic [VC_W-1:0]   sel_vc;
    logic              wr_end;
    logic [ADDR_W-1:0] head_next;
    logic              head_end;

    assign wr_end = wr_eop | cell_mode;

    vcm_rr_pick #(.NUM_VC(NUM_VC), .VC_W(VC_W)) i_pick (
        .req   (ready_v),
        .last  (last_vc),
        .grant (pick_vc),
        .any   (any_ready)
    );

    always_comb begin
        if (busy)           phase = OUT_MIDDLE;
        else if (any_ready) phase = OUT_FIRST;
        else                phase = OUT_IDLE;
    end

    assign sel_vc   = (phase == OUT_MIDDLE) ? cur_vc : pick_vc;
    assign rd_valid = (phase != OUT_IDLE);
    assign rd_vc    = sel_vc;
    assign rd_addr  = head_a[sel_vc];
    assign rd_last  = head_end;

    vcm_link_mem #(.ADDR_W(ADDR_W)) i_links (
        .clk       (clk),
        .cell_we   (wr_valid),
        .cell_addr (wr_addr),
        .cell_end  (wr_end),
        .link_we   (|link_we_v),
        .link_from (tail_a[wr_vc]),
        .link_to   (wr_addr),
        .rd_addr   (rd_addr),
        .rd_next   (head_next),
        .rd_end    (head_end)
    );

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        vcm_vc_queue #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_queue (
            .clk       (clk),
            .rst       (rst),
            .push      (wr_valid && (wr_vc == VC_W'(g))),
            .push_addr (wr_addr),
            .push_end  (wr_end),
            .pop       (rd_valid && (sel_vc == VC_W'(g))),
            .pop_end   (head_end),
            .pop_next  (head_next),
            .head      (head_a[g]),
            .tail      (tail_a[g]),
            .link_we   (link_we_v[g]),
            .pkt_ready (ready_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cur_vc  <= '0;
            last_vc <= VC_W'(NUM_VC - 1);
        end else begin
            busy <= rd_valid && !rd_last;
            if (rd_valid) cur_vc <= sel_vc;
            if (phase == OUT_FIRST) last_vc <= pick_vc;
        end
    end
endmodule

// File: rtl/vcm_merge_sched_chk.sv
module vcm_merge_sched_chk #(
    parameter int unsigned NUM_VC = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned VC_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cell_mode,
    input logic              wr_valid,
    input logic [VC_W-1:0]   wr_vc,
    input logic              wr_eop,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_valid,
    input logic [VC_W-1:0]   rd_vc,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_last
);
    localparam int unsigned CNT_W = $clog2((1 << ADDR_W) + 1);

    logic [CNT_W-1:0] pend [NUM_VC];
    logic             mid;
    logic             any_pend;

    always_comb begin
        any_pend = 1'b0;
        for (int i = 0; i < NUM_VC; i++) any_pend |= (pend[i] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid <= 1'b0;
            for (int i = 0; i < NUM_VC; i++) pend[i] <= '0;
        end else begin
            mid <= rd_valid && !rd_last;
            for (int i = 0; i < NUM_VC; i++) begin
                pend[i] <= pend[i]
                    + CNT_W'(wr_valid && (wr_eop || cell_mode) && (wr_vc == VC_W'(i)))
                    - CNT_W'(rd_valid && rd_last && (rd_vc == VC_W'(i)));
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) $past(rst) |-> !rd_valid);

    p_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_last) |=> (rd_valid && rd_vc == $past(rd_vc)));

    p_wait_complete_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !mid) |-> (pend[rd_vc] != '0));

    p_idle_no_packet_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!any_pend && !mid));

    p_addr_known_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$isunknown(rd_addr));
endmodule

bind vcm_merge_sched vcm_merge_sched_chk #(
    .NUM_VC(NUM_VC), .ADDR_W(ADDR_W), .VC_W(VC_W)
) i_chk (
    .clk(clk), .rst(rst), .cell_mode(cell_mode), .wr_valid(wr_valid),
    .wr_vc(wr_vc), .wr_eop(wr_eop), .wr_addr(wr_addr), .rd_valid(rd_valid),
    .rd_vc(rd_vc), .rd_addr(rd_addr), .rd_last(rd_last)
);

// File: tb/test_vcm_merge_sched.sv
module test_vcm_merge_sched;
    localparam int NV = 4;
    localparam int NA = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cell_mode = 1'b0;
    logic       wr_valid = 1'b0;
    logic [1:0] wr_vc = '0;
    logic       wr_eop = 1'b0;
    logic [3:0] wr_addr = '0;
    logic       rd_valid;
    logic [1:0] rd_vc;
    logic [3:0] rd_addr;
    logic       rd_last;

    int checks = 0;
    int failures = 0;

    // Reference state of the queues.
    int mq_addr [NV][NA];
    bit mq_end  [NV][NA];
    int mq_n    [NV];
    int mpk     [NV];
    bit mbusy;
    int mcur;
    int mlast;
    bit in_use  [NA];
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    vcm_merge_sched i_vcm_merge_sched (
        .clk(clk), .rst(rst), .cell_mode(cell_mode), .wr_valid(wr_valid),
        .wr_vc(wr_vc), .wr_eop(wr_eop), .wr_addr(wr_addr), .rd_valid(rd_valid),
        .rd_vc(rd_vc), .rd_addr(rd_addr), .rd_last(rd_last)
    );

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < NV; v++) begin
            mq_n[v] = 0;
            mpk[v] = 0;
        end
        for (int a = 0; a < NA; a++) in_use[a] = 1'b0;
        mbusy = 1'b0;
        mcur = 0;
        mlast = NV - 1;
    endtask

    // One slot: check outputs, update the model, drive the next write.
    task automatic slot(input bit do_wr, input int vc, input bit eop, input bit mode);
        bit ev;
        int evc;
        int ea;
        bit el;
        int alloc;
        int freed;
        @(negedge clk);
        ev = 1'b0;
        evc = 0;
        if (mbusy) begin
            ev = 1'b1;
            evc = mcur;
        end else begin
            for (int i = 1; i <= NV; i++) begin
                if (!ev && mpk[(mlast + i) % NV] > 0) begin
                    ev = 1'b1;
                    evc = (mlast + i) % NV;
                end
            end
        end
        if (ev) chk(rd_valid == 1'b1, "R3 ready packet served", int'(rd_valid), 1);
        else    chk(rd_valid == 1'b0, "R8 idle without complete packet", int'(rd_valid), 0);
        freed = -1;
        if (ev) begin
            ea = mq_addr[evc][0];
            el = mq_end[evc][0];
            if (mbusy) chk(int'(rd_vc) == evc, "R4 same circuit until packet end", int'(rd_vc), evc);
            else       chk(int'(rd_vc) == evc, "R6 round-robin choice", int'(rd_vc), evc);
            chk(int'(rd_addr) == ea, "R2 token order", int'(rd_addr), ea);
            chk(rd_last == el, "R5 R9 packet end flag", int'(rd_last), int'(el));
            for (int k = 0; k < NA - 1; k++) begin
                mq_addr[evc][k] = mq_addr[evc][k + 1];
                mq_end[evc][k] = mq_end[evc][k + 1];
            end
            mq_n[evc]--;
            if (el) mpk[evc]--;
            if (!mbusy) mlast = evc;
            mbusy = !el;
            mcur = evc;
            freed = ea;
        end
        alloc = -1;
        if (do_wr) begin
            for (int a = NA - 1; a >= 0; a--) if (!in_use[a]) alloc = a;
        end
        if (freed >= 0) in_use[freed] = 1'b0;
        cell_mode = mode;
        if (alloc >= 0) begin
            in_use[alloc] = 1'b1;
            mq_addr[vc][mq_n[vc]] = alloc;
            mq_end[vc][mq_n[vc]] = eop | mode;
            mq_n[vc]++;
            if (eop | mode) mpk[vc]++;
            wr_valid = 1'b1;
            wr_vc = 2'(vc);
            wr_eop = eop;
            wr_addr = 4'(alloc);
        end else begin
            wr_valid = 1'b0;
            wr_eop = 1'b0;
        end
    endtask

    function automatic int free_count();
        int n = 0;
        for (int a = 0; a < NA; a++) if (!in_use[a]) n++;
        return n;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: nothing offered straight after reset
        chk(rd_valid == 1'b0, "R1 reset idle", int'(rd_valid), 0);

        // R8: partial packet on circuit 1 keeps the output idle
        slot(1'b1, 1, 1'b0, 1'b0);
        slot(1'b1, 1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) slot(1'b0, 0, 1'b0, 1'b0);
        // R3: closing cell makes it eligible next slot; R7: two packets queued
        slot(1'b1, 1, 1'b1, 1'b0);
        slot(1'b1, 1, 1'b1, 1'b0);
        slot(1'b1, 2, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) slot(1'b0, 0, 1'b0, 1'b0);

        // R9: cell mode on circuit 3 with wr_eop low
        for (int i = 0; i < 6; i++) slot(1'b1, 3, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) slot(1'b0, 0, 1'b0, 1'b0);

        // Sweep of write densities and closing probabilities (R2 R4 R5 R6 R7 R10)
        for (int dens = 1; dens <= 4; dens++) begin
            for (int endp = 1; endp <= 3; endp++) begin
                for (int c = 0; c < 400; c++) begin
                    bit w;
                    bit e;
                    w = (rnd() % 4) < dens;
                    e = (rnd() % 4) < endp || free_count() <= NV;
                    slot(w, int'(rnd() % NV), e, 1'b0);
                end
            end
        end

        // Mode toggled per write: sampled at write time (R9)
        for (int c = 0; c < 800; c++) begin
            bit e;
            e = (rnd() % 3) == 0 || free_count() <= NV;
            slot((rnd() % 2) == 0, int'(rnd() % NV), e, (rnd() % 2) == 0);
        end
        for (int i = 0; i < 60; i++) slot(1'b0, 0, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule